// File: doc/BRIEF.md
# Strobed Bidirectional Parallel Port

This block is a general purpose parallel port of `WIDTH` lines with one handshake strobe line and an interrupt request. A simple synchronous register interface with two addresses reaches it: a control register and a port data register. The control register sets the port direction, chooses push-pull or open-drain line drivers, and enables the interrupt.

In input mode the strobe pin is an input. It passes through a two-flop synchroniser. A falling edge copies the pin values into the data register and marks new data as pending. In output mode the data register drives the lines, and the values hold until software writes the register again. Each such write also sends an active-low strobe pulse of `PULSE_LEN` clock cycles out on the strobe pin.

The interrupt request is an open-drain style signal. It asks the pad to pull low while captured data is pending and interrupts are enabled, and it is released at all other times. Reading the data register clears the pending flag.

Top module: `strobe_port`

## Requirements
- R1: After reset the control register is 0 (input mode, push-pull, interrupt disabled) and the data register is 0. Also `pinOe` is 0, `strobeOe` is 0, `strobeOutN` is 1 and `irqPullLow` is 0.
- R2: A write with `regAddr`=1 loads the control register from bit 0 (direction, 1 = output), bit 1 (open-drain) and bit 2 (interrupt enable). A read with `regAddr`=1 returns those three bits with all upper bits 0. Read data appears on `regRdData` in the cycle after `regRdEn` and holds until the next read.
- R3: In input mode, a falling edge on `strobeIn` copies `pinIn` into the data register within three clock cycles. A rising edge copies nothing.
- R4: In output push-pull mode, `pinOe` is all ones and `pinOut` equals the data register. `pinOut` does not change until the next data register write (`regAddr`=0).
- R5: In output open-drain mode, `pinOut` is all zeros and `pinOe` is the inverse of the data register. A 1 bit releases its line and a 0 bit pulls it low.
- R6: In output mode, every data register write drives `strobeOutN` low from the next cycle for exactly `PULSE_LEN` cycles, with `strobeOe` high. A write during a pulse restarts the full length.
- R7: In input mode a data register write produces no strobe pulse. In output mode a `strobeIn` edge leaves the data register and the pending flag unchanged.
- R8: A capture sets the pending flag. `irqPullLow` is high exactly when the flag is set and the interrupt enable bit is 1.
- R9: Reading the data register returns its value and clears the pending flag. A capture in the same cycle keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 1 | Register select: 0 data, 1 control |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | WIDTH | Write data |
| regRdData | output | WIDTH | Registered read data |
| pinIn | input | WIDTH | Line values from the pads |
| pinOut | output | WIDTH | Line drive values |
| pinOe | output | WIDTH | Per-line output enable |
| strobeIn | input | 1 | Strobe pin value from the pad |
| strobeOutN | output | 1 | Strobe drive value, active low |
| strobeOe | output | 1 | Strobe output enable |
| irqPullLow | output | 1 | Interrupt request: 1 pulls the line low |

## Verification
A wrong direction or driver mode bit is visible at once, in the same cycle, on `pinOe` and `pinOut`. A stuck or miscounted pulse counter shows as a strobe low time that differs from `PULSE_LEN`, so the bench counts low cycles on `strobeOutN` one by one. A synchroniser or edge detector fault appears as a missed capture, an extra capture on the rising edge, or a capture in output mode. The next data read shows it, and `irqPullLow` shows it within three cycles. A pending flag that fails to clear keeps `irqPullLow` asserted in the cycle after the read.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int unsigned CFG_BITS = 3;

  typedef struct packed {
    logic irqEn;
    logic openDrain;
    logic dirOut;
  } portCfg_t;

  typedef struct packed {
    logic loadFromBus;
    logic loadCtrl;
    logic captureFromPins;
    logic readData;
    logic readCtrl;
  } portStrobes_t;
endpackage

// File: rtl/strobe_port_ctrl.sv
module strobe_port_ctrl
  import strobe_port_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regAddr,
  input  logic         regWrEn,
  input  logic         regRdEn,
  input  logic         strobeIn,
  input  portCfg_t     cfg,
  output portStrobes_t strobes,
  output logic         strobeOutN,
  output logic         irqPending
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic syncA, syncB, syncPrev;
  logic strobeFell;
  logic [CNT_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      syncPrev <= 1'b1;
    end else begin
      syncA    <= strobeIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign strobeFell = syncPrev & ~syncB;

  always_comb begin
    strobes.loadFromBus     = regWrEn && (regAddr == ADDR_DATA);
    strobes.loadCtrl        = regWrEn && (regAddr == ADDR_CTRL);
    strobes.readData        = regRdEn && (regAddr == ADDR_DATA);
    strobes.readCtrl        = regRdEn && (regAddr == ADDR_CTRL);
    strobes.captureFromPins = strobeFell && !cfg.dirOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobes.loadFromBus && cfg.dirOut) begin
      pulseCnt <= CNT_LOAD;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign strobeOutN = (pulseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if (strobes.captureFromPins) begin
      irqPending <= 1'b1;
    end else if (strobes.readData) begin
      irqPending <= 1'b0;
    end
  end

  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_DATA && cfg.dirOut) |=> !strobeOutN);
  assert_no_pulse_input_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOutN && !cfg.dirOut) |=> strobeOutN);
  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureFromPins |=> irqPending);
  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_DATA && !strobes.captureFromPins) |=> !irqPending);
endmodule

// File: rtl/strobe_port_dp.sv
module strobe_port_dp
  import strobe_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strobes,
  input  logic [WIDTH-1:0] regWrData,
  input  logic [WIDTH-1:0] pinIn,
  output portCfg_t         cfg,
  output logic [WIDTH-1:0] regRdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  logic [WIDTH-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (strobes.loadCtrl) begin
      cfg <= portCfg_t'(regWrData[CFG_BITS-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobes.captureFromPins) begin
      dataReg <= pinIn;
    end else if (strobes.loadFromBus) begin
      dataReg <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (strobes.readData) begin
      regRdData <= dataReg;
    end else if (strobes.readCtrl) begin
      regRdData <= {{(WIDTH-CFG_BITS){1'b0}}, cfg};
    end
  end

  always_comb begin
    if (!cfg.dirOut) begin
      pinOut = '0;
      pinOe  = '0;
    end else if (cfg.openDrain) begin
      pinOut = '0;
      pinOe  = ~dataReg;
    end else begin
      pinOut = dataReg;
      pinOe  = '1;
    end
  end

  assert_capture_pins_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureFromPins |=> (dataReg == $past(pinIn)));
  assert_hold_out_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.dirOut && !strobes.loadFromBus && !strobes.loadCtrl) |=> $stable(pinOut));
  assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.dirOut && cfg.openDrain) |-> ((pinOut & pinOe) == '0));
  assert_output_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.dirOut && !strobes.loadFromBus) |=> $stable(dataReg));
endmodule

// File: rtl/strobe_port.sv
module strobe_port
  import strobe_port_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic             strobeIn,
  output logic             strobeOutN,
  output logic             strobeOe,
  output logic             irqPullLow
);
  portCfg_t     cfg;
  portStrobes_t strobes;
  logic         irqPending;

  strobe_port_ctrl #(.PULSE_LEN(PULSE_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .strobeIn(strobeIn), .cfg(cfg), .strobes(strobes),
    .strobeOutN(strobeOutN), .irqPending(irqPending)
  );

  strobe_port_dp #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .pinIn(pinIn), .cfg(cfg), .regRdData(regRdData), .pinOut(pinOut),
    .pinOe(pinOe)
  );

  assign strobeOe   = cfg.dirOut;
  assign irqPullLow = irqPending & cfg.irqEn;

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.irqEn |-> !irqPullLow);
  assert_strobe_idle_input_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobeOe |-> (pinOe == '0));
endmodule

// File: tb/test_strobe_port.sv
module test_strobe_port;
  localparam int unsigned WIDTH = 8;
  localparam int unsigned PULSE_LEN = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regAddr = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0;
  logic [WIDTH-1:0] regWrData = '0, pinIn = '0;
  logic strobeIn = 1'b1;
  logic [WIDTH-1:0] regRdData, pinOut, pinOe;
  logic strobeOutN, strobeOe, irqPullLow;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_port #(.WIDTH(WIDTH), .PULSE_LEN(PULSE_LEN)) i_strobe_port (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .strobeIn(strobeIn),
    .strobeOutN(strobeOutN), .strobeOe(strobeOe), .irqPullLow(irqPullLow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic addr, input logic [WIDTH-1:0] val);
    @(negedge clk);
    regAddr = addr; regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic addr, output logic [WIDTH-1:0] val);
    @(negedge clk);
    regAddr = addr; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    val = regRdData;
  endtask

  task automatic strobePulseIn(input logic [WIDTH-1:0] val);
    @(negedge clk);
    pinIn = val; strobeIn = 1'b0;
    repeat (4) @(negedge clk);
    strobeIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic countLow(output int n);
    n = 0;
    while (!strobeOutN && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testReset;
    logic [WIDTH-1:0] v;
    check("R1 pinOe", pinOe, 0);
    check("R1 strobeOe", strobeOe, 0);
    check("R1 strobeOutN", strobeOutN, 1);
    check("R1 irq", irqPullLow, 0);
    regRead(1'b1, v); check("R1 ctrl", v, 0);
    regRead(1'b0, v); check("R1 data", v, 0);
  endtask

  task automatic testCtrlReg;
    logic [WIDTH-1:0] v;
    regWrite(1'b1, 8'hFD);
    regRead(1'b1, v); check("R2 ctrl readback", v, 8'h05);
    @(negedge clk); check("R2 read data holds", regRdData, 8'h05);
    regWrite(1'b1, 8'h00);
  endtask

  task automatic testInputCapture;
    logic [WIDTH-1:0] v;
    regWrite(1'b1, 8'h04);
    strobePulseIn(8'hA5);
    check("R8 irq after capture", irqPullLow, 1);
    pinIn = 8'h11;
    @(negedge clk); strobeIn = 1'b0;
    repeat (4) @(negedge clk);
    pinIn = 8'h22; strobeIn = 1'b1;
    repeat (4) @(negedge clk);
    regRead(1'b0, v); check("R3 falling edge value", v, 8'h11);
    check("R9 irq cleared by read", irqPullLow, 0);
    regRead(1'b0, v); check("R3 rising edge no capture", v, 8'h11);
    regWrite(1'b1, 8'h00);
    strobePulseIn(8'h5A);
    check("R8 irq masked", irqPullLow, 0);
    regWrite(1'b1, 8'h04);
    check("R8 pending then enabled", irqPullLow, 1);
    regRead(1'b0, v); check("R3 second capture", v, 8'h5A);
    check("R9 cleared", irqPullLow, 0);
  endtask

  task automatic testOutputModes;
    int n;
    regWrite(1'b1, 8'h01);
    regWrite(1'b0, 8'h96);
    check("R4 pinOe", pinOe, 8'hFF);
    check("R4 pinOut", pinOut, 8'h96);
    check("R6 strobeOe", strobeOe, 1);
    countLow(n); check("R6 pulse length", n, PULSE_LEN);
    repeat (5) @(negedge clk);
    check("R4 pinOut holds", pinOut, 8'h96);
    regWrite(1'b1, 8'h03);
    check("R5 od pinOut", pinOut, 8'h00);
    check("R5 od pinOe", pinOe, 8'h69);
    regWrite(1'b0, 8'h0F);
    check("R5 od pinOe new", pinOe, 8'hF0);
    countLow(n); check("R6 pulse od", n, PULSE_LEN);
  endtask

  task automatic testRetrigger;
    int n;
    regWrite(1'b1, 8'h01);
    regWrite(1'b0, 8'h01);
    regWrite(1'b0, 8'h02);
    check("R6 low at retrigger", strobeOutN, 0);
    countLow(n); check("R6 restarted length", n, PULSE_LEN);
  endtask

  task automatic testIgnored;
    logic [WIDTH-1:0] v;
    int n;
    regWrite(1'b1, 8'h05);
    regWrite(1'b0, 8'h3C);
    countLow(n);
    strobePulseIn(8'hFF);
    check("R7 no irq in output", irqPullLow, 0);
    regRead(1'b0, v); check("R7 data kept in output", v, 8'h3C);
    regWrite(1'b1, 8'h00);
    regWrite(1'b0, 8'h77);
    n = 0;
    for (int i = 0; i < 6; i++) begin
      if (!strobeOutN) n++;
      @(negedge clk);
    end
    check("R7 no pulse in input", n, 0);
    check("R1 input oe", pinOe, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testCtrlReg();
        testInputCapture();
        testOutputModes();
        testRetrigger();
        testIgnored();
      end
      begin
        repeat (20000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule